// File: doc/BRIEF.md
# Two-Level Priority Bus Arbiter

This block decides which master may drive a shared downstream bus. It serves a set of external masters, each signalling through an active-low request line, plus one internal requester that stands for the bridge itself. A per-requester select bit places each requester in a high tier or a low tier. The high tier rotates among its members, and the whole low tier takes one turn in that rotation. When the low tier's turn comes up, the low tier's own rotation picks one of its members.

Grants are registered and leave the block active-low for external masters and active-high for the internal requester. A new grant is issued only while the bus is idle. While a transfer runs, the arbiter can only withdraw the current grant, and it does so when a different requester should be served next. A withdrawn grant line stays off for a parameterised number of cycles. With no eligible request, the idle bus is parked either on the bridge or on the last master that won. A strap turns the internal arbiter off. External request line 0 then becomes an incoming grant for the bridge, and no external grant is ever driven.

Top module: `two_tier_bus_arbiter`

## Requirements
- R1: While reset is applied, every external grant output is high (deasserted) and the internal grant is low.
- R2: At most one grant (external or internal) is asserted in any cycle.
- R3: Bit i of `grp_high` places external requester i in the high tier when 1 and in the low tier when 0. `own_grp_high` does the same for the internal requester. A requester in one tier never competes in the other.
- R4: Within the high tier, the next grant goes to the first eligible slot after the last high-tier winner. Slots are ordered external 0..NUM_EXT-1, then internal, then one shared slot for the whole low tier, wrapping around. Right after reset the scan starts at external 0.
- R5: When the shared low-tier slot wins, the grant goes to the first eligible low-tier requester after the last low-tier winner, in index order with wrap. The first low-tier scan after reset starts at external 0.
- R6: No grant becomes newly asserted in the cycle after a cycle with `bus_idle` low. During such a busy cycle the current grant is removed only when the arbitration winner is another requester, and is otherwise kept.
- R7: A grant line that has just been deasserted stays deasserted for at least GAP_CYCLES (default 2) cycles, and a requester inside that window is not eligible.
- R8: When the bus is idle, no request is eligible and `park_on_self` is 1, the internal grant is asserted one cycle later, unless that line is inside its R7 window.
- R9: When the bus is idle, no request is eligible and `park_on_self` is 0, the grant goes to (or stays with) the last requester that won arbitration. This is the internal requester if none has won since reset.
- R10: With `arb_off` high, the internal grant follows, one cycle later, the expression (`ext_req_n[0]` low) AND (`own_req` OR `bus_idle`).
- R11: With `arb_off` high, all external grant outputs stay high regardless of the request lines, and `ext_req_n[0]` is not treated as a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_n | input | NUM_EXT | Active-low external requests; bit 0 is the incoming grant when `arb_off` is high |
| own_req | input | 1 | Internal (bridge) request, active high |
| bus_idle | input | 1 | High when no transfer is in progress |
| grp_high | input | NUM_EXT | Tier select per external requester, 1 = high tier |
| own_grp_high | input | 1 | Tier select of the internal requester, 1 = high tier |
| park_on_self | input | 1 | 1 = park the idle bus on the bridge, 0 = on the last winner |
| arb_off | input | 1 | Strap: internal arbiter disabled |
| ext_gnt_n | output | NUM_EXT | Active-low grants to external masters |
| own_gnt | output | 1 | Grant to the internal requester, active high |

## Verification
Four properties are checked on every cycle: only one grant is ever active, no grant is newly asserted right after a busy cycle, a grant line that falls is still low on the next edge, and no external grant is driven while the arbiter is disabled. The properties cannot show which requester is chosen. The rotation order inside each tier, the low tier taking a single turn in the high-tier rotation, and the choice of park target by `park_on_self` are shown only by the bench's scenarios. The same holds for the disabled-mode grant pass-through and for a blocked requester being skipped in favour of parking.

// File: rtl/tba_pkg.sv
package tba_pkg;

   // Largest external requester count the block is sized for
   localparam int MAX_EXT = 16;

   // Index reached by stepping 'step' positions forward from 'base' on a
   // ring of 'w' entries
   function automatic int slot_after(input int base, input int step, input int w);
      return (base + step) % w;
   endfunction

endpackage

// File: rtl/tba_rr_pick.sv
module tba_rr_pick
   import tba_pkg::*;
#(
   parameter int W  = 4,
   parameter int IW = 3
) (
   input  logic [W-1:0]  elig,
   input  logic [IW-1:0] last,
   output logic          found,
   output logic [IW-1:0] pick
);

   localparam int CW = (W > 1) ? $clog2(W) : 1;

   if (IW < CW) begin : g_bad_iw
      $error("tba_rr_pick: IW too narrow for W");
   end

   logic [CW-1:0] cand;

   // Scan forward from the slot after 'last'; first eligible slot wins
   always_comb begin
      found = 1'b0;
      pick  = last;
      cand  = '0;
      for (int k = 1; k <= W; k++) begin
         cand = CW'(slot_after(int'(last), k, W));
         if (!found && elig[cand]) begin
            found = 1'b1;
            pick  = IW'(cand);
         end
      end
   end

endmodule

// File: rtl/tba_gap_guard.sv
module tba_gap_guard #(
   parameter int LINES = 4,
   parameter int GAP   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] cur,
   input  logic [LINES-1:0] nxt,
   output logic [LINES-1:0] blk
);

   localparam int STAGES = GAP - 1;

   if (GAP < 2) begin : g_bad_gap
      $error("tba_gap_guard: GAP must be at least 2");
   end

   logic [LINES-1:0] stage [STAGES];

   // stage[0] marks lines that fell at the last edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[0] <= '0;
      else        stage[0] <= cur & ~nxt;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage[s] <= '0;
         else        stage[s] <= stage[s-1];
      end
   end

   always_comb begin
      blk = '0;
      for (int s = 0; s < STAGES; s++) blk = blk | stage[s];
   end

endmodule

// File: rtl/two_tier_bus_arbiter.sv
module two_tier_bus_arbiter
   import tba_pkg::*;
#(
   parameter int NUM_EXT    = 9,
   parameter int GAP_CYCLES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EXT-1:0] ext_req_n,
   input  logic               own_req,
   input  logic               bus_idle,
   input  logic [NUM_EXT-1:0] grp_high,
   input  logic               own_grp_high,
   input  logic               park_on_self,
   input  logic               arb_off,
   output logic [NUM_EXT-1:0] ext_gnt_n,
   output logic               own_gnt
);

   localparam int N   = NUM_EXT + 1;     // requesters incl. the bridge
   localparam int S   = N + 1;           // high-tier slots incl. low-tier slot
   localparam int IW  = $clog2(S);
   localparam int OWN = N - 1;           // index of the internal requester
   localparam logic [IW-1:0] LO_SLOT = IW'(N);
   localparam logic [IW-1:0] OWN_IDX = IW'(OWN);

   if (NUM_EXT < 1 || NUM_EXT > MAX_EXT) begin : g_bad_ext
      $error("two_tier_bus_arbiter: NUM_EXT out of range");
   end

   // ---------------- request conditioning ----------------
   logic [N-1:0] req, grp, blk;
   logic [N-1:0] lo_elig;
   logic [S-1:0] hi_elig;

   assign req     = {own_req, ~ext_req_n};
   assign grp     = {own_grp_high, grp_high};
   assign lo_elig = req & ~grp & ~blk;
   assign hi_elig = {|lo_elig, req & grp & ~blk};

   // ---------------- state ----------------
   logic [N-1:0]  gnt_q, gnt_nxt;
   logic [IW-1:0] hi_ptr, lo_ptr, last_win;

   // ---------------- two rotations ----------------
   logic          hi_found, lo_found;
   logic [IW-1:0] hi_pick, lo_pick;

   tba_rr_pick #(.W(S), .IW(IW)) u_hi_rr (
      .elig  (hi_elig),
      .last  (hi_ptr),
      .found (hi_found),
      .pick  (hi_pick)
   );

   tba_rr_pick #(.W(N), .IW(IW)) u_lo_rr (
      .elig  (lo_elig),
      .last  (lo_ptr),
      .found (lo_found),
      .pick  (lo_pick)
   );

   logic          win_low, win_any;
   logic [IW-1:0] win_idx, park_idx;
   logic [N-1:0]  win_vec, park_vec;
   logic          win_holds, park_blocked, new_grant, grant_in;

   assign win_low  = hi_found && (hi_pick == LO_SLOT);
   assign win_any  = hi_found && (!win_low || lo_found);
   assign win_idx  = win_low ? lo_pick : hi_pick;
   assign park_idx = park_on_self ? OWN_IDX : last_win;
   assign grant_in = ~ext_req_n[0];

   always_comb begin
      for (int i = 0; i < N; i++) begin
         win_vec[i]  = (IW'(i) == win_idx);
         park_vec[i] = (IW'(i) == park_idx);
      end
   end

   assign win_holds    = |(gnt_q & win_vec);
   assign park_blocked = |(blk & park_vec);
   assign new_grant    = !arb_off && bus_idle && win_any && !win_holds;

   // ---------------- next grant ----------------
   always_comb begin
      gnt_nxt = gnt_q;
      if (arb_off) begin
         gnt_nxt      = '0;
         gnt_nxt[OWN] = grant_in && (own_req || bus_idle);
      end else if (bus_idle) begin
         if (win_any)           gnt_nxt = win_vec;
         else if (park_blocked) gnt_nxt = '0;
         else                   gnt_nxt = park_vec;
      end else if (win_any && !win_holds) begin
         gnt_nxt = '0;
      end
   end

   tba_gap_guard #(.LINES(N), .GAP(GAP_CYCLES)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .cur   (gnt_q),
      .nxt   (gnt_nxt),
      .blk   (blk)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_q    <= '0;
         hi_ptr   <= LO_SLOT;
         lo_ptr   <= IW'(N - 1);
         last_win <= OWN_IDX;
      end else begin
         gnt_q <= gnt_nxt;
         if (new_grant) begin
            last_win <= win_idx;
            if (win_low) begin
               hi_ptr <= LO_SLOT;
               lo_ptr <= win_idx;
            end else begin
               hi_ptr <= win_idx;
            end
         end
      end
   end

   assign ext_gnt_n = ~gnt_q[NUM_EXT-1:0];
   assign own_gnt   = gnt_q[OWN];

   // ---------------- assertions ----------------
   // R2
   single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_q));

   // R6
   busy_no_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_idle && !arb_off) |=> ((gnt_q & ~$past(gnt_q)) == '0));

   // R11
   off_no_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arb_off |=> (gnt_q[NUM_EXT-1:0] == '0));

   for (genvar g = 0; g < N; g++) begin : g_gap_chk
      // R7
      gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || arb_off)
         $fell(gnt_q[g]) |=> !gnt_q[g]);
   end

endmodule

// File: tb/two_tier_bus_arbiter_bench.sv
module two_tier_bus_arbiter_bench;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NE = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NE-1:0] ext_req_n = '1;
   logic          own_req = 1'b0;
   logic          bus_idle = 1'b1;
   logic [NE-1:0] grp_high = 9'b000000110;
   logic          own_grp_high = 1'b1;
   logic          park_on_self = 1'b1;
   logic          arb_off = 1'b0;
   logic [NE-1:0] ext_gnt_n;
   logic          own_gnt;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   two_tier_bus_arbiter u_two_tier_bus_arbiter (
      .clk          (clk),
      .rst_n        (rst_n),
      .ext_req_n    (ext_req_n),
      .own_req      (own_req),
      .bus_idle     (bus_idle),
      .grp_high     (grp_high),
      .own_grp_high (own_grp_high),
      .park_on_self (park_on_self),
      .arb_off      (arb_off),
      .ext_gnt_n    (ext_gnt_n),
      .own_gnt      (own_gnt)
   );

   // {ext requests active-high [8:0], own_req, bus_idle, park_on_self, expected grants [9:0]}
   // expected bit 9 = internal grant, bits 8..0 = external grants
   localparam int NV = 14;
   localparam logic [21:0] VEC [NV] = '{
      {9'b000000000, 1'b0, 1'b1, 1'b1, 10'h200},
      {9'b000000010, 1'b0, 1'b1, 1'b1, 10'h002},
      {9'b000100110, 1'b0, 1'b0, 1'b1, 10'h000},
      {9'b000100110, 1'b0, 1'b1, 1'b1, 10'h004},
      {9'b000100110, 1'b0, 1'b1, 1'b1, 10'h020},
      {9'b010100110, 1'b1, 1'b1, 1'b1, 10'h002},
      {9'b010100110, 1'b1, 1'b1, 1'b1, 10'h004},
      {9'b010100110, 1'b1, 1'b1, 1'b1, 10'h200},
      {9'b010100110, 1'b1, 1'b1, 1'b1, 10'h080},
      {9'b010000000, 1'b0, 1'b0, 1'b1, 10'h080},
      {9'b000000000, 1'b0, 1'b1, 1'b0, 10'h080},
      {9'b000000000, 1'b0, 1'b1, 1'b1, 10'h200},
      {9'b010000000, 1'b0, 1'b1, 1'b1, 10'h200},
      {9'b010000000, 1'b0, 1'b1, 1'b1, 10'h080}
   };

   function automatic string vec_tag(input int v);
      case (v)
         0, 11:        return "R8 park on bridge";
         1:            return "R3 R4 high tier";
         2, 9:         return "R6 busy";
         3:            return "R7 R4 skip blocked";
         4, 8:         return "R5 low tier slot";
         5, 6, 7:      return "R4 high rotation";
         10:           return "R9 park on last winner";
         default:      return "R7 gap then park";
      endcase
   endfunction

   function automatic logic [9:0] grants();
      return {own_gnt, ~ext_gnt_n};
   endfunction

   task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin : stim
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 reset", grants(), 10'h000);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         ext_req_n    = ~VEC[v][21:13];
         own_req      = VEC[v][12];
         bus_idle     = VEC[v][11];
         park_on_self = VEC[v][10];
         step();
         check(vec_tag(v), grants(), VEC[v][9:0]);
         check("R2 one grant", 10'($countones(grants()) <= 1), 10'h001);
      end

      // reset again mid-run
      @(negedge clk);
      rst_n = 1'b0;
      ext_req_n = '1;
      own_req = 1'b0;
      #1;
      check("R1 reset reapplied", grants(), 10'h000);
      @(negedge clk);
      arb_off = 1'b1;
      rst_n = 1'b1;

      // R10 R11 disabled mode: line 0 is an incoming grant
      ext_req_n = 9'b111100110;   // grant_in low, ext 3 and 4 requesting
      bus_idle  = 1'b0;
      own_req   = 1'b0;
      step();
      check("R10 busy no own request", grants(), 10'h000);
      bus_idle = 1'b1;
      step();
      check("R10 park with grant in", grants(), 10'h200);
      check("R11 no external grant", {1'b0, ~ext_gnt_n}, 10'h000);
      bus_idle = 1'b0;
      own_req  = 1'b1;
      step();
      check("R10 own request with grant in", grants(), 10'h200);
      ext_req_n[0] = 1'b1;
      step();
      check("R10 grant in removed", grants(), 10'h000);
      ext_req_n = 9'b000000000;
      bus_idle  = 1'b1;
      step();
      check("R11 all lines low ignored", {1'b0, ~ext_gnt_n}, 10'h000);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule